// File: doc/BRIEF.md
# Prioritized DMA Channel Arbiter

This block chooses which channel of a multi-channel DMA engine is served next. Each channel raises single-item or multi-item request lines. The arbiter ignores channels that are switched off and then ranks the rest. A channel whose urgent bit is set beats every channel whose bit is clear. Among channels of equal rank, the smallest channel index wins.

The winner holds the grant for a run of items. A multi-item request gets a run of 2^n items, where n is that channel's 4-bit size exponent. A single-item request gets a run of one item. The arbiter does not choose again until the data mover has reported every item of the run, even if a higher-ranked request arrives in the meantime.

The processor always has first use of the bus. While it is busy, the transfer enable is held low and item strobes are ignored. The run then resumes on the same channel. The urgent bits sit in a small register that has separate set and clear write vectors.

Top module: `dma_chan_arbiter`

## Requirements
- R1: Among enabled requesters whose urgent bit is clear, the lowest channel index is granted.
- R2: An enabled requester whose urgent bit is set outranks every requester whose bit is clear. Among several urgent requesters, the lowest index wins.
- R3: A 1 in bit i of `prio_set_i` sets urgent bit i, and a 1 in bit i of `prio_clr_i` clears it. A 0 in either vector leaves the bit unchanged. If both vectors have a 1 at the same position, the clear wins. `prio_o` shows the register state.
- R4: A granted multi-item request runs for 2^n accepted items, where n is the channel's 4-bit field `arb_exp_i[4*i+3:4*i]`. Any n above 10 runs 1024 items. On the edge that accepts the last item, `grant_vld_o` falls.
- R5: While a run is in progress, `grant_ch_o` stays constant and no other request preempts it, whatever its rank.
- R6: While `cpu_busy_i` is high, `xfer_en_o` is low and `item_done_i` is not counted. The run then continues on the same channel without a new choice.
- R7: A single-item request is granted a run of exactly one item. If a channel raises both kinds of request, the multi-item request sets the run length.
- R8: A channel with its `burst_only_i` bit set ignores its single-item request.
- R9: A channel whose enable bit is low is never granted. If the granted channel's enable drops during a run, the run ends on the next accepted item.
- R10: After reset, `grant_vld_o` and `xfer_en_o` are 0, `grant_ch_o` is 0 and `prio_o` is all zeros.
- R11: A new grant appears on the first clock edge at which no grant is held and an eligible request is present. After a run ends, `grant_vld_o` is therefore low for at least one cycle.
- R12: An item is accepted on a clock edge where `item_done_i` and `xfer_en_o` are both high. `xfer_en_o` is high exactly when a grant is held and `cpu_busy_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | NUM_CH | Per-channel enable |
| prio_set_i | input | NUM_CH | Write-one-to-set vector for the urgent bits |
| prio_clr_i | input | NUM_CH | Write-one-to-clear vector for the urgent bits |
| prio_o | output | NUM_CH | Current urgent bits |
| arb_exp_i | input | 4*NUM_CH | Per-channel run-size exponent, 4 bits per channel |
| burst_only_i | input | NUM_CH | Per-channel flag that ignores single-item requests |
| sreq_i | input | NUM_CH | Single-item request lines |
| breq_i | input | NUM_CH | Multi-item request lines |
| cpu_busy_i | input | 1 | Processor holds the bus |
| item_done_i | input | 1 | Data mover finished one item |
| grant_ch_o | output | CH_W | Granted channel index |
| grant_vld_o | output | 1 | A grant is held |
| xfer_en_o | output | 1 | Data mover may move an item |

## Verification
A run counter loaded with the wrong length shows up as `grant_vld_o` falling too early or too late. The bench measures this in item strobes, including the saturated 1024-item run. A wrong ranking or a wrong priority register shows up in `grant_ch_o` on the edge after the requests are applied. A stale enable or a broken busy gate shows up at once on `xfer_en_o`, or as a run that ends on the wrong edge after the bus is released.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int EXP_W   = 4;
  localparam int MAX_EXP = 10;
  localparam int LEN_W   = MAX_EXP + 1;

  // 2^e items, saturated at 2^MAX_EXP
  function automatic logic [LEN_W-1:0] run_len(input logic [EXP_W-1:0] e);
    logic [LEN_W-1:0] l;
    if (e > EXP_W'(MAX_EXP)) begin
      l = '0;
      l[MAX_EXP] = 1'b1;
    end else begin
      l = LEN_W'(1) << e;
    end
    return l;
  endfunction
endpackage

// File: rtl/dma_prio_reg.sv
module dma_prio_reg #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] prio_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prio_o[g] <= 1'b0;
      else if (clr_i[g]) prio_o[g] <= 1'b0;
      else if (set_i[g]) prio_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] hi_i,
  output logic [CH_W-1:0]   idx_o,
  output logic              vld_o
);
  logic [NUM_CH-1:0] hi_req, sel;

  assign hi_req = req_i & hi_i;
  assign sel    = (|hi_req) ? hi_req : req_i;
  assign vld_o  = |req_i;

  // lowest set index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (sel[i]) idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma_run_ctr.sv
module dma_run_ctr
  import dma_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  input  logic             abort_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (step_i) cnt_q <= cnt_q - LEN_W'(1);
  end

  // abort: channel disabled, end on this item
  assign done_o = step_i && ((cnt_q == LEN_W'(1)) || abort_i);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH-1:0]       prio_set_i,
  input  logic [NUM_CH-1:0]       prio_clr_i,
  output logic [NUM_CH-1:0]       prio_o,
  input  logic [NUM_CH*EXP_W-1:0] arb_exp_i,
  input  logic [NUM_CH-1:0]       burst_only_i,
  input  logic [NUM_CH-1:0]       sreq_i,
  input  logic [NUM_CH-1:0]       breq_i,
  input  logic                    cpu_busy_i,
  input  logic                    item_done_i,
  output logic [CH_W-1:0]         grant_ch_o,
  output logic                    grant_vld_o,
  output logic                    xfer_en_o
);
  logic [NUM_CH-1:0] elig;
  logic [EXP_W-1:0]  exp_arr [NUM_CH];
  logic [CH_W-1:0]   win_ch, grant_ch_q;
  logic              win_vld, grant_vld_q, start, accept, run_done;
  logic [LEN_W-1:0]  win_len;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_exp
    assign exp_arr[g] = arb_exp_i[g*EXP_W +: EXP_W];
  end

  assign elig = en_i & (breq_i | (sreq_i & ~burst_only_i));

  dma_prio_reg #(.NUM_CH(NUM_CH)) u_prio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (prio_set_i),
    .clr_i (prio_clr_i),
    .prio_o(prio_o)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i(elig),
    .hi_i (prio_o),
    .idx_o(win_ch),
    .vld_o(win_vld)
  );

  // burst request sets the run length when present
  assign win_len = breq_i[win_ch] ? run_len(exp_arr[win_ch]) : LEN_W'(1);
  assign start   = !grant_vld_q && win_vld;
  assign accept  = xfer_en_o && item_done_i;

  dma_run_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .len_i  (win_len),
    .step_i (accept),
    .abort_i(!en_i[grant_ch_q]),
    .done_o (run_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_vld_q <= 1'b0;
      grant_ch_q  <= '0;
    end else if (start) begin
      grant_vld_q <= 1'b1;
      grant_ch_q  <= win_ch;
    end else if (run_done) begin
      grant_vld_q <= 1'b0;
    end
  end

  assign grant_vld_o = grant_vld_q;
  assign grant_ch_o  = grant_ch_q;
  assign xfer_en_o   = grant_vld_q && !cpu_busy_i;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NUM_CH = 32,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] prio_set_i,
  input logic [NUM_CH-1:0] prio_clr_i,
  input logic [NUM_CH-1:0] prio_o,
  input logic              cpu_busy_i,
  input logic              item_done_i,
  input logic [CH_W-1:0]   grant_ch_o,
  input logic              grant_vld_o,
  input logic              xfer_en_o
);
  logic [NUM_CH-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_i;
  end

  p_cpu_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_busy_i |-> !xfer_en_o);

  p_xfer_needs_grant_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |-> grant_vld_o);

  p_hold_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && !(item_done_i && xfer_en_o)) |=> (grant_vld_o && $stable(grant_ch_o)));

  p_prio_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_set_i & ~prio_clr_i) != '0 |=>
      (prio_o & $past(prio_set_i & ~prio_clr_i)) == $past(prio_set_i & ~prio_clr_i));

  p_prio_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_clr_i != '0 |=> (prio_o & $past(prio_clr_i)) == '0);

  p_grant_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_vld_o) |-> en_q[grant_ch_o]);
endmodule

bind dma_chan_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .prio_set_i (prio_set_i),
  .prio_clr_i (prio_clr_i),
  .prio_o     (prio_o),
  .cpu_busy_i (cpu_busy_i),
  .item_done_i(item_done_i),
  .grant_ch_o (grant_ch_o),
  .grant_vld_o(grant_vld_o),
  .xfer_en_o  (xfer_en_o)
);

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;
  localparam int N = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  en_i = '1, prio_set_i = '0, prio_clr_i = '0, prio_o;
  logic [N*4-1:0] arb_exp_i = '0;
  logic [N-1:0]  burst_only_i = '0, sreq_i = '0, breq_i = '0;
  logic          cpu_busy_i = 1'b0, item_done_i = 1'b0;
  logic [4:0]    grant_ch_o;
  logic          grant_vld_o, xfer_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5ns clk_i = ~clk_i;

  dma_chan_arbiter #(.NUM_CH(N)) u0 (.*);

  typedef struct packed {
    logic [31:0] pr, en, sr, br, bo;
    logic [4:0]  ch;
    logic        vld;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0030, 32'h0, 5'd4, 1'b1},          // R1
    '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h0, 5'd0, 1'b1},          // R1
    '{32'h0000_0100, 32'hFFFF_FFFF, 32'h0, 32'h0000_0102, 32'h0, 5'd8, 1'b1},  // R2
    '{32'h8000_0400, 32'hFFFF_FFFF, 32'h0, 32'h8000_0403, 32'h0, 5'd10, 1'b1}, // R2
    '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 5'd31, 1'b1}, // R2
    '{32'h0, 32'hFFFF_FFFE, 32'h0, 32'h0000_0005, 32'h0, 5'd2, 1'b1},          // R9
    '{32'h0, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0, 32'h0000_0001, 5'd1, 1'b1},  // R8
    '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 5'd0, 1'b0},  // R8
    '{32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0}           // R9
  };

  task automatic tick();
    @(posedge clk_i);
    #1ns;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic set_exp(input int ch, input int e);
    arb_exp_i[ch*4 +: 4] = 4'(e);
  endtask

  initial begin
    #(200000 * 5ns);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    #12ns;
    rst_ni = 1'b1;
    tick();
    // R10 reset state
    chk(grant_vld_o == 0 && xfer_en_o == 0, "R10 vld/xfer", {grant_vld_o, xfer_en_o}, 0);
    chk(grant_ch_o == 0 && prio_o == 0, "R10 ch/prio", prio_o, 0);

    // vector table, all runs one item long
    foreach (VEC[k]) begin
      prio_clr_i = '1; tick(); prio_clr_i = '0;
      prio_set_i = VEC[k].pr; tick(); prio_set_i = '0;
      en_i = VEC[k].en; sreq_i = VEC[k].sr; breq_i = VEC[k].br; burst_only_i = VEC[k].bo;
      tick();
      chk(grant_vld_o == VEC[k].vld, $sformatf("R1/R2/R8/R9 vec%0d vld", k), grant_vld_o, VEC[k].vld);
      if (VEC[k].vld)
        chk(grant_ch_o == VEC[k].ch, $sformatf("R1/R2 vec%0d ch", k), grant_ch_o, VEC[k].ch);
      sreq_i = '0; breq_i = '0; burst_only_i = '0; en_i = '1;
      if (grant_vld_o) begin
        item_done_i = 1; tick(); item_done_i = 0;
      end
      tick();
    end
    prio_clr_i = '1; tick(); prio_clr_i = '0;

    // R3 priority register
    prio_set_i = 32'h28; tick();
    chk(prio_o == 32'h28, "R3 set", prio_o, 32'h28);
    prio_set_i = '0; tick();
    chk(prio_o == 32'h28, "R3 zero no effect", prio_o, 32'h28);
    prio_clr_i = 32'h8; tick(); prio_clr_i = '0;
    chk(prio_o == 32'h20, "R3 clear", prio_o, 32'h20);
    prio_set_i = 32'h20; prio_clr_i = 32'h20; tick();
    prio_set_i = '0; prio_clr_i = '0;
    chk(prio_o == 32'h0, "R3 clear wins", prio_o, 0);

    // R4/R5/R11 run of 8, no preemption, gap, then saturated run
    set_exp(2, 3); set_exp(1, 15);
    breq_i = 32'h4; tick();
    chk(grant_vld_o && grant_ch_o == 2, "R4 grant ch2", grant_ch_o, 2);
    breq_i = 32'h6; item_done_i = 1;
    repeat (7) tick();
    chk(grant_vld_o && grant_ch_o == 2, "R5 held after 7", grant_ch_o, 2);
    tick();
    chk(!grant_vld_o, "R4 end after 8", grant_vld_o, 0);
    item_done_i = 0; breq_i = 32'h2; tick();
    chk(grant_vld_o && grant_ch_o == 1, "R11 next grant", grant_ch_o, 1);
    breq_i = '0; item_done_i = 1; n = 0;
    do begin tick(); n++; end while (grant_vld_o && n < 1100);
    chk(n == 1024, "R4 saturated length", n, 1024);
    item_done_i = 0; tick();

    // R7 single gets one item; both kinds use burst length
    set_exp(5, 5); sreq_i = 32'h20; tick();
    chk(grant_vld_o && grant_ch_o == 5, "R7 single grant", grant_ch_o, 5);
    sreq_i = '0; item_done_i = 1; tick();
    chk(!grant_vld_o, "R7 single one item", grant_vld_o, 0);
    item_done_i = 0;
    set_exp(5, 2); sreq_i = 32'h20; breq_i = 32'h20; tick();
    sreq_i = '0; breq_i = '0; item_done_i = 1;
    repeat (3) tick();
    chk(grant_vld_o, "R7 burst precedence held", grant_vld_o, 1);
    tick();
    chk(!grant_vld_o, "R7 burst precedence end", grant_vld_o, 0);
    item_done_i = 0; tick();

    // R6/R12 CPU busy pauses the run
    set_exp(6, 2); breq_i = 32'h40; tick(); breq_i = 32'h1;
    cpu_busy_i = 1; item_done_i = 1; #1ns;
    chk(!xfer_en_o, "R6 xfer low when busy", xfer_en_o, 0);
    repeat (5) tick();
    chk(grant_vld_o && grant_ch_o == 6, "R6 held while busy", grant_ch_o, 6);
    cpu_busy_i = 0; #1ns;
    chk(xfer_en_o, "R12 xfer resumes", xfer_en_o, 1);
    repeat (3) tick();
    chk(grant_vld_o && grant_ch_o == 6, "R6 same channel", grant_ch_o, 6);
    tick();
    chk(!grant_vld_o, "R6 run ends after 4", grant_vld_o, 0);
    breq_i = '0; item_done_i = 0; tick();

    // R9 disable mid-run ends at next item
    set_exp(7, 4); breq_i = 32'h80; tick();
    item_done_i = 1; repeat (2) tick();
    en_i[7] = 1'b0; tick();
    chk(!grant_vld_o, "R9 disabled ends run", grant_vld_o, 0);
    item_done_i = 0; tick();
    chk(!grant_vld_o, "R9 disabled not regranted", grant_vld_o, 0);
    breq_i = '0; en_i = '1;

    finish_run();
  end
endmodule